// File: doc/BRIEF.md
# E1 Receive Frame-Slip Elastic Store

This block carries 8-bit E1 channel bytes from the timing of the recovered line to the frame timing of the system backplane. The line side presents one byte at a time with its channel number (0 to 31). The byte is written into a store that holds exactly two frames. The system side pulls bytes with a read strobe and marks the read of channel 0 with a frame-start flag. From there the block walks through the 32 channels of the frame it has chosen.

The block judges how far the writer is ahead of the reader only at a frame start. If the lead has drifted outside a 26-channel tolerance on either side of the nominal one-frame spacing, the block takes a controlled slip. It does not advance to the other frame, so the reader ends up one whole frame earlier or later. It pulses a slip flag and records whether a frame was repeated or deleted. A maskable copy of the pulse serves as an interrupt request.

Top module: `rx_slip_buffer`

## Requirements
- R1: While reset is held and right after it, `rd_data`, `slip_pulse`, `slip_dir` and `slip_irq` are all 0.
- R2: Each write stores `wr_data` at slot {frame bit, `wr_chan`}. The frame bit starts at 0 and flips after channel 31 is written, so the store holds 64 bytes across two frames.
- R3: A read returns its byte on `rd_data` in the cycle after the strobe. A read with `rd_sof` takes channel 0 of the selected frame. Every other read takes the next channel.
- R4: After reset the reader sits one frame behind the writer. If one full frame is written and reading then runs in step with writing, every read returns the byte written one frame earlier on the same channel.
- R5: The lead is D = (W − 32·F) mod 64, where W is the 6-bit slot after the last write and F is the frame the frame-start read would normally enter. When 6 ≤ D ≤ 58 (32 ± 26 channels) no slip occurs.
- R6: When D < 6 at a frame-start read, the reader stays in the frame it just finished, which repeats that frame. `slip_dir` becomes 1.
- R7: When D > 58 at a frame-start read, the reader also stays in its current frame. Because the writer has lapped it, this deletes a frame, and `slip_dir` becomes 0.
- R8: `slip_pulse` is high for exactly the one cycle after a frame-start read that slipped, and at no other time. Slips are always of whole frames.
- R9: `slip_irq` pulses together with `slip_pulse` only if `irq_mask` was 0 during the frame-start read. `slip_pulse` is not affected by the mask.
- R10: `slip_dir` keeps its value until the next slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both strobes are qualified on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe from line side |
| wr_chan | input | 5 | Channel number of the byte written |
| wr_data | input | 8 | Byte written |
| rd_en | input | 1 | Read strobe from system side |
| rd_sof | input | 1 | Marks the read of channel 0 (system frame start) |
| irq_mask | input | 1 | 1 suppresses the slip interrupt |
| rd_data | output | 8 | Byte read, valid the cycle after `rd_en` |
| slip_pulse | output | 1 | One-cycle pulse for each frame slip |
| slip_dir | output | 1 | Last slip: 1 = frame repeated, 0 = frame deleted |
| slip_irq | output | 1 | Slip pulse gated by `irq_mask` |

## Verification
The hardest state to reach is a slip that comes from gradual drift and not from a preloaded lead. The lead changes by only one channel per frame, so 27 frames of steady rate mismatch must pass before the threshold is crossed. The bench runs the writer one byte per frame faster than the reader, then one byte slower. It predicts the exact frame index of the slip and checks that no other frame slips. Separate directed preloads place the lead exactly on both edges of the tolerance window and one step past each.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DELETE = 2'd2
  } slip_e;
endpackage

// File: rtl/rsb_wr_ctrl.sv
module rsb_wr_ctrl #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  output logic [CH_W:0]   wr_addr,
  output logic [CH_W:0]   wr_pos
);
  logic [CH_W:0] wpos_q, wpos_d;

  // frame bit from position, channel from line side
  assign wr_addr = {wpos_q[CH_W], wr_chan};
  assign wr_pos  = wpos_q;

  always_comb begin
    wpos_d = wpos_q;
    if (wr_en) wpos_d = wr_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wpos_q <= '0;
    else if (wr_en) wpos_q <= wpos_d;
  end

  p_wpos_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wpos_q));
endmodule

// File: rtl/rsb_rd_ctrl.sv
module rsb_rd_ctrl
  import rsb_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int HYST = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_sof,
  input  logic [CH_W:0] wr_pos,
  output logic [CH_W:0] rd_addr,
  output slip_e         slip_kind
);
  localparam int AW    = CH_W + 1;
  localparam int NCH   = 1 << CH_W;
  localparam int GUARD = NCH - HYST;
  localparam logic [AW-1:0] LO_LIM = AW'(GUARD);
  localparam logic [AW-1:0] HI_LIM = AW'(2 * NCH - GUARD);

  logic [AW-1:0] rpos_q, rpos_d;
  logic          rfrm_q, rfrm_d;
  logic          f_nom, f_sel;
  logic [AW-1:0] lead;

  always_comb begin
    f_nom     = ~rfrm_q;
    lead      = wr_pos - {f_nom, {CH_W{1'b0}}};
    slip_kind = SLIP_NONE;
    if (rd_en && rd_sof) begin
      if (lead < LO_LIM)      slip_kind = SLIP_REPEAT;
      else if (lead > HI_LIM) slip_kind = SLIP_DELETE;
    end
    f_sel   = (slip_kind != SLIP_NONE) ? rfrm_q : f_nom;
    rd_addr = rd_sof ? {f_sel, {CH_W{1'b0}}} : rpos_q;
    rpos_d  = rd_addr + 1'b1;
    rfrm_d  = rd_sof ? f_sel : rfrm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpos_q <= '0;
      rfrm_q <= 1'b1;
    end else if (rd_en) begin
      rpos_q <= rpos_d;
      rfrm_q <= rfrm_d;
    end
  end

  p_rpos_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rpos_q) && $stable(rfrm_q));
  p_slip_only_at_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_kind != SLIP_NONE) |-> (rd_en && rd_sof));
  p_slip_keeps_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_kind != SLIP_NONE) |=> rfrm_q == $past(rfrm_q));
endmodule

// File: rtl/rsb_store.sv
module rsb_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata_q));
endmodule

// File: rtl/rsb_slip_rpt.sv
module rsb_slip_rpt
  import rsb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slip_e slip_kind,
  input  logic  irq_mask,
  output logic  slip_pulse,
  output logic  slip_dir,
  output logic  slip_irq
);
  logic pulse_q, pulse_d, dir_q, dir_d, irq_q, irq_d;

  always_comb begin
    pulse_d = (slip_kind != SLIP_NONE);
    irq_d   = pulse_d && !irq_mask;
    dir_d   = dir_q;
    if (pulse_d) dir_d = (slip_kind == SLIP_REPEAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      irq_q   <= irq_d;
      dir_q   <= dir_d;
    end
  end

  assign slip_pulse = pulse_q;
  assign slip_dir   = dir_q;
  assign slip_irq   = irq_q;

  p_irq_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slip_irq |-> slip_pulse && $past(!irq_mask));
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_pulse |-> $stable(slip_dir));
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer
  import rsb_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int BYTE_W = 8,
  parameter int HYST   = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_sof,
  input  logic              irq_mask,
  output logic [BYTE_W-1:0] rd_data,
  output logic              slip_pulse,
  output logic              slip_dir,
  output logic              slip_irq
);
  localparam int AW = CH_W + 1;

  logic          rst_meta, rst_sync;
  logic [AW-1:0] wr_addr, wr_pos, rd_addr;
  slip_e         slip_kind;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  rsb_wr_ctrl #(.CH_W(CH_W)) u_wr (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_addr(wr_addr), .wr_pos(wr_pos));

  rsb_rd_ctrl #(.CH_W(CH_W), .HYST(HYST)) u_rd (
    .clk(clk), .rst_n(rst_sync), .rd_en(rd_en), .rd_sof(rd_sof),
    .wr_pos(wr_pos), .rd_addr(rd_addr), .slip_kind(slip_kind));

  rsb_store #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_sync), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data));

  rsb_slip_rpt u_rpt (
    .clk(clk), .rst_n(rst_sync), .slip_kind(slip_kind), .irq_mask(irq_mask),
    .slip_pulse(slip_pulse), .slip_dir(slip_dir), .slip_irq(slip_irq));

  p_pulse_after_sof_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    slip_pulse |-> $past(rd_en && rd_sof));
endmodule

// File: tb/rx_slip_buffer_test.sv
module rx_slip_buffer_test;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, rd_sof, irq_mask;
  logic [4:0] wr_chan;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       slip_pulse, slip_dir, slip_irq;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  rx_slip_buffer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sof(rd_sof), .irq_mask(irq_mask), .rd_data(rd_data),
    .slip_pulse(slip_pulse), .slip_dir(slip_dir), .slip_irq(slip_irq));

  function automatic logic [7:0] mk(input int seq, input int ch);
    return {seq[2:0], ch[4:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input int ch, input logic [7:0] wd,
                      input logic re, input logic sof);
    wr_en = we; wr_chan = ch[4:0]; wr_data = wd; rd_en = re; rd_sof = sof;
    @(negedge clk);
    wr_en = 0; rd_en = 0; rd_sof = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; rd_sof = 0; irq_mask = 0;
    wr_chan = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk);
    check(rd_data == 0 && slip_pulse == 0, "R1 held", {rd_data, slip_pulse}, 0);
    do_reset();
    check(rd_data == 0, "R1 rd_data", rd_data, 0);
    check(slip_pulse == 0 && slip_dir == 0 && slip_irq == 0, "R1 flags",
          {slip_pulse, slip_dir, slip_irq}, 0);
  endtask

  task automatic t_nominal();
    int bad = 0, slips = 0, first_act = 0, first_exp = 0;
    do_reset();
    for (int k = 0; k < 32; k++) step(1, k, mk(0, k), 0, 0);
    for (int n = 0; n < 3; n++) begin
      for (int k = 0; k < 32; k++) begin
        step(1, k, mk(n + 1, k), 1, k == 0);
        if (rd_data != mk(n, k) && bad == 0) begin
          first_act = rd_data; first_exp = mk(n, k);
        end
        if (rd_data != mk(n, k)) bad++;
        if (slip_pulse) slips++;
      end
    end
    check(bad == 0, "R4/R3/R2 lockstep data", first_act, first_exp);
    check(slips == 0, "R5 no slip at nominal lead", slips, 0);
  endtask

  task automatic t_window();
    // upper edge: lead 58, no slip
    do_reset();
    for (int k = 0; k < 32; k++) step(1, k, mk(0, k), 0, 0);
    for (int k = 0; k < 26; k++) step(1, k, mk(1, k), 0, 0);
    step(0, 0, 0, 1, 1);
    check(slip_pulse == 0, "R5 lead 58 keeps", slip_pulse, 0);
    check(rd_data == mk(0, 0), "R5 lead 58 data", rd_data, mk(0, 0));
    // lead 59: frame deleted
    do_reset();
    for (int k = 0; k < 32; k++) step(1, k, mk(0, k), 0, 0);
    for (int k = 0; k < 27; k++) step(1, k, mk(1, k), 0, 0);
    step(0, 0, 0, 1, 1);
    check(slip_pulse == 1, "R7 lead 59 slips", slip_pulse, 1);
    check(slip_dir == 0, "R7 delete direction", slip_dir, 0);
    check(rd_data == mk(1, 0), "R7 skipped to newer frame", rd_data, mk(1, 0));
    step(0, 0, 0, 1, 0);
    check(slip_pulse == 0, "R8 pulse one cycle", slip_pulse, 0);
    check(rd_data == mk(1, 1), "R3 next channel", rd_data, mk(1, 1));
    // lower edge: lead 6, no slip
    do_reset();
    for (int k = 0; k < 6; k++) step(1, k, mk(0, k), 0, 0);
    step(0, 0, 0, 1, 1);
    check(slip_pulse == 0, "R5 lead 6 keeps", slip_pulse, 0);
    check(rd_data == mk(0, 0), "R5 lead 6 data", rd_data, mk(0, 0));
    // lead 5: frame repeated
    do_reset();
    for (int k = 0; k < 5; k++) step(1, k, mk(0, k), 0, 0);
    step(0, 0, 0, 1, 1);
    check(slip_pulse == 1 && slip_dir == 1, "R6 lead 5 repeats",
          {slip_pulse, slip_dir}, 3);
  endtask

  task automatic t_repeat();
    int bad = 0;
    do_reset();
    for (int k = 0; k < 32; k++) step(1, k, mk(0, k), 0, 0);
    for (int k = 0; k < 32; k++) step(1, k, mk(1, k), 0, 0);
    irq_mask = 0;
    step(0, 0, 0, 1, 1);
    check(slip_pulse == 1 && slip_dir == 1, "R6 full store repeats",
          {slip_pulse, slip_dir}, 3);
    check(slip_irq == 1, "R9 unmasked irq", slip_irq, 1);
    check(rd_data == mk(1, 0), "R6 reads frame 1", rd_data, mk(1, 0));
    for (int k = 1; k < 32; k++) begin
      step(0, 0, 0, 1, 0);
      if (rd_data != mk(1, k) || slip_pulse) bad++;
    end
    check(bad == 0, "R3 frame walk after slip", bad, 0);
    check(slip_dir == 1, "R10 dir held", slip_dir, 1);
    irq_mask = 1;
    step(0, 0, 0, 1, 1);
    irq_mask = 0;
    check(slip_pulse == 1, "R9 pulse despite mask", slip_pulse, 1);
    check(slip_irq == 0, "R9 masked irq", slip_irq, 0);
    check(rd_data == mk(1, 0), "R6 frame repeated again", rd_data, mk(1, 0));
  endtask

  // fast: 33 writes per 32-read frame; slow: 31 writes per frame
  task automatic t_drift(input bit fast);
    int wch = 0, slips = 0, at = -1, bad_time = 0, frames = 30;
    int per = fast ? 33 : 32;
    int nwr = fast ? 33 : 31;
    logic dir_seen = 0;
    do_reset();
    for (int k = 0; k < 32; k++) step(1, k, mk(0, k), 0, 0);
    wch = 0;
    for (int j = 0; j < frames; j++) begin
      for (int c = 0; c < per; c++) begin
        logic we = (c < nwr);
        step(we, wch, 8'h5A, c < 32, c == 0);
        if (we) wch = (wch + 1) % 32;
        if (slip_pulse) begin
          slips++;
          if (c != 0) bad_time++;
          if (at < 0) begin at = j; dir_seen = slip_dir; end
        end
      end
    end
    if (fast) begin
      check(slips == 1 && at == 27, "R7 drift slip frame", at, 27);
      check(dir_seen == 0, "R7 drift delete dir", dir_seen, 0);
    end else begin
      check(slips == 1 && at == 27, "R6 drift slip frame", at, 27);
      check(dir_seen == 1, "R6 drift repeat dir", dir_seen, 1);
    end
    check(bad_time == 0, "R8 slip only at frame start", bad_time, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; rd_sof = 0; irq_mask = 0;
    wr_chan = 0; wr_data = 0;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_window();
    t_repeat();
    t_drift(1'b1);
    t_drift(1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule